// File: doc/BRIEF.md
# Watchdog Timer with Timer Control Register

This block watches the processor for lost control. A prescaler runs on the system clock and feeds a wider up counter. Software starts the watchdog through an 8-bit control register at address 01H. Once started, software can never stop it. Software must keep writing the register to restart the count from zero. If the count wraps before that, the block sets a sticky watchdog flag and raises a one-cycle warm-reset request. Two constant outputs give the memory locations (2FFCh and 2FFDh) from which the processor reloads its program counter.

The same register also serves two neighbouring timers. Each has an enable bit and a status flag. The flag is set by hardware when that timer's tick input rises, passes through a two-flop synchroniser, and its enable bit is 1. Software clears the flag.

Access is a plain register bus: address, write strobe, write data and combinational read data. The bus carries single control accesses rather than a data stream, so it has no valid/ready handshake and never stalls. A write takes effect at the clock edge on which the strobe is high.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, the register at 01H reads 00h, the warm-reset output is 0, and the watchdog is not counting.
- R2: The register sits at address 01H. Its bits are: bit 5 watchdog-run, bit 4 watchdog-flag, bit 3 base-timer enable, bit 2 base-timer flag, bit 1 real-time enable, bit 0 real-time flag. Bits 7:6 read as 0. Any other address reads 00h, and a write to another address changes nothing.
- R3: A write with bit 5 = 1 starts the watchdog. The first warm-reset pulse follows exactly 2^(PRE_W+CNT_W) cycles after the edge that took the write. Later pulses repeat with the same period. A write with bit 5 = 1 while the watchdog is running does not disturb the count.
- R4: Once running, the watchdog cannot be stopped: bit 5 keeps reading 1. A write with bit 5 = 0 clears the prescaler and the counter, so the next pulse comes 2^(PRE_W+CNT_W) cycles after that write's edge.
- R5: The warm-reset request lasts one cycle. The vector outputs are constant at 2FFCh (low) and 2FFDh (high).
- R6: The watchdog flag (bit 4) reads 1 in the cycle of a warm-reset pulse and from then on. Register writes never change it; only reset clears it.
- R7: A rising edge on a tick input sets that timer's flag, provided its enable bit is 1. The flag reads 1 once two edges have passed after the first edge that samples the input high. A falling edge sets nothing, and neither does a rise while the enable bit is 0.
- R8: Writing 0 to a flag bit (2 or 0) clears that flag. Writing 1 leaves it unchanged and never sets it.
- R9: When a hardware set and a software clear of the same flag fall on one edge, the flag ends up 1.
- R10: The enable bits 3 and 1 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also drives the prescaler |
| rst_n | input | 1 | Active-low power-on reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| base_tick_i | input | 1 | Asynchronous tick from the base timer |
| rtc_tick_i | input | 1 | Asynchronous tick from the real-time counter |
| warm_rst_o | output | 1 | One-cycle warm-reset request |
| vec_lo_o | output | PC_W | Address of the low byte of the restart vector |
| vec_hi_o | output | PC_W | Address of the high byte of the restart vector |

## Verification
The bench builds the block with PRE_W=2 and CNT_W=4, which gives a 64-cycle watchdog period instead of 65536 cycles. With that period, several full expiries fit in one short run. The bench can then check, to the exact cycle, the first pulse, a restart mid-period, a write that must not restart the count, and the periodic pulse that follows. The tick paths use the default two synchroniser stages, so the bench can place a hardware set on the same edge as a software clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Field order equals bit order: run is bit 5, rtc_hit is bit 0.
  typedef struct packed {
    logic run;       // bit 5
    logic dog_hit;   // bit 4
    logic base_en;   // bit 3
    logic base_hit;  // bit 2
    logic rtc_en;    // bit 1
    logic rtc_hit;   // bit 0
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/wdog_tick_edge.sv
module wdog_tick_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], tick_i};
  end

  assign rise_o = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int PRE_W = 4,
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic wrap_o,
  output logic pulse_o
);
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic             pre_full, cnt_full, pulse_q;

  assign pre_full = &pre;
  assign cnt_full = &cnt;
  assign wrap_o   = run_i & ~clear_i & pre_full & cnt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (clear_i) begin
      pre <= '0;
      cnt <= '0;
    end else if (run_i) begin
      pre <= pre + 1'b1;
      if (pre_full) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= wrap_o;
  end

  assign pulse_o = pulse_q;

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (pre == '0) && (cnt == '0));

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clear_i) |=> $stable(cnt) && $stable(pre));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h01,
  parameter int                PRE_W    = 4,
  parameter int                CNT_W    = 12,
  parameter int                SYNC_STG = 2,
  parameter int                PC_W     = 16,
  parameter logic [PC_W-1:0]   VEC_LO   = 'h2FFC,
  parameter logic [PC_W-1:0]   VEC_HI   = 'h2FFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              base_tick_i,
  input  logic              rtc_tick_i,
  output logic              warm_rst_o,
  output logic [PC_W-1:0]   vec_lo_o,
  output logic [PC_W-1:0]   vec_hi_o
);
  import wdog_pkg::*;

  localparam int PAD_W = 8 - CTL_W;

  ctl_t ctl, wr_v;
  logic hit, addr_ok, base_rise, rtc_rise, wrap, clr;
  logic unused_hi;

  assign addr_ok   = (reg_addr == REG_ADDR);
  assign hit       = reg_wr & addr_ok;
  assign wr_v      = ctl_t'(reg_wdata[CTL_W-1:0]);
  assign unused_hi = &{1'b0, reg_wdata[7:CTL_W]};
  assign clr       = hit & ~wr_v.run & ctl.run;

  wdog_tick_edge #(.SYNC_STAGES(SYNC_STG)) u_base_edge (
    .clk(clk), .rst_n(rst_n), .tick_i(base_tick_i), .rise_o(base_rise));

  wdog_tick_edge #(.SYNC_STAGES(SYNC_STG)) u_rtc_edge (
    .clk(clk), .rst_n(rst_n), .tick_i(rtc_tick_i), .rise_o(rtc_rise));

  wdog_count #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run_i(ctl.run), .clear_i(clr),
    .wrap_o(wrap), .pulse_o(warm_rst_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (hit && wr_v.run) ctl.run <= 1'b1;
      if (wrap)            ctl.dog_hit <= 1'b1;
      if (hit) begin
        ctl.base_en <= wr_v.base_en;
        ctl.rtc_en  <= wr_v.rtc_en;
      end
      if (base_rise && ctl.base_en)      ctl.base_hit <= 1'b1;
      else if (hit && !wr_v.base_hit)    ctl.base_hit <= 1'b0;
      if (rtc_rise && ctl.rtc_en)        ctl.rtc_hit <= 1'b1;
      else if (hit && !wr_v.rtc_hit)     ctl.rtc_hit <= 1'b0;
    end
  end

  assign reg_rdata = addr_ok ? {{PAD_W{1'b0}}, ctl} : 8'h00;
  assign vec_lo_o  = VEC_LO;
  assign vec_hi_o  = VEC_HI;

  // R4
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.run |=> ctl.run);

  // R6
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |-> ctl.dog_hit);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.dog_hit |=> ctl.dog_hit);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_rise && ctl.base_en && hit && !wr_v.base_hit) |=> ctl.base_hit);

  // R3
  pulse_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |-> ctl.run);
endmodule

// File: tb/wdog_ctrl_tb.sv
module wdog_ctrl_tb;
  localparam int PRE_W = 2;
  localparam int CNT_W = 4;
  localparam int N     = 1 << (PRE_W + CNT_W);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h01;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       base_tick = 1'b0, rtc_tick = 1'b0;
  logic       warm_rst;
  logic [15:0] vec_lo, vec_hi;

  int total = 0, bad = 0, cyc = 0, last_cyc = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .base_tick_i(base_tick), .rtc_tick_i(rtc_tick),
    .warm_rst_o(warm_rst), .vec_lo_o(vec_lo), .vec_hi_o(vec_hi));

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h01;
    last_cyc = cyc;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s: rdata=%h expected=%h", tag, reg_rdata, e);
    end
    reg_addr = 8'h01;
  endtask

  // monitor: every warm-reset pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && warm_rst) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3/R5: pulse at cycle %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          bad++;
          $display("FAIL R3/R4: pulse at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(8'h01, 8'h00, "R1 reset register");
    total++;
    if (warm_rst !== 1'b0) begin
      bad++; $display("FAIL R1: warm_rst=%b expected=0", warm_rst);
    end
    // R5 vectors
    total++;
    if (vec_lo !== 16'h2FFC || vec_hi !== 16'h2FFD) begin
      bad++; $display("FAIL R5: vectors=%h/%h expected=2ffc/2ffd", vec_lo, vec_hi);
    end

    // R10 enables
    wr(8'h01, 8'h0A);
    rd_chk(8'h01, 8'h0A, "R10 enables");

    // R7 base tick rising edge sets bit 2
    @(negedge clk); base_tick = 1'b1;
    repeat (3) @(posedge clk);
    rd_chk(8'h01, 8'h0E, "R7 base rise");

    // R8 writing 1 keeps / does not set; writing 0 clears
    wr(8'h01, 8'h0F);
    rd_chk(8'h01, 8'h0E, "R8 write one no set");
    wr(8'h01, 8'h0A);
    rd_chk(8'h01, 8'h0A, "R8 write zero clears");

    // R7 falling edge does nothing
    @(negedge clk); base_tick = 1'b0;
    repeat (4) @(posedge clk);
    rd_chk(8'h01, 8'h0A, "R7 falling edge");

    // R7 rise while disabled does nothing
    wr(8'h01, 8'h08);
    @(negedge clk); rtc_tick = 1'b1;
    repeat (4) @(posedge clk);
    rd_chk(8'h01, 8'h08, "R7 disabled rise");

    // R9 hardware set and software clear on one edge
    @(negedge clk); base_tick = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_addr = 8'h01; reg_wdata = 8'h08; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0;
    rd_chk(8'h01, 8'h0C, "R9 set wins");

    // R2 decode
    wr(8'h02, 8'hFF);
    rd_chk(8'h01, 8'h0C, "R2 foreign write ignored");
    rd_chk(8'h02, 8'h00, "R2 foreign read zero");

    // R3 start the watchdog
    wr(8'h01, 8'h20);
    exp_q.push_back(last_cyc + N);
    rd_chk(8'h01, 8'h20, "R3 run bit");
    repeat (10) @(negedge clk);
    wr(8'h01, 8'h20);   // R3 no restart
    repeat (20) @(negedge clk);

    // R4 write zero only restarts the count
    wr(8'h01, 8'h00);
    exp_q.delete();
    exp_q.push_back(last_cyc + N);
    exp_q.push_back(last_cyc + 2 * N);
    rd_chk(8'h01, 8'h20, "R4 cannot stop");

    repeat (N + 6) @(negedge clk);
    // R6 flag set after expiry
    rd_chk(8'h01, 8'h30, "R6 flag after pulse");
    wr(8'h01, 8'h20);
    rd_chk(8'h01, 8'h30, "R6 write cannot clear");

    repeat (N + 6) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3: pending pulses=%0d expected=0", exp_q.size());
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule